// File: doc/BRIEF.md
# Key-Protected Data NVM Write Controller

This block sits between a small CPU register bus and a byte-wide on-chip data store that stands in for nonvolatile cells. Software sees four byte registers: a location pointer, a data buffer, a control/status register and a write-only key port. A read completes at once: the byte at the pointer is copied into the buffer in the same cycle, so the next bus access sees it. A write takes a parameterised number of clock cycles. It is accepted only directly after an exact two-byte unlock sequence on the key port, and only when the enable bit is set in the control write that launches it.

At the end of a write the block clears its busy bit on its own and raises a completion flag, which also drives an interrupt line. Software clears that flag itself. A warm reset or a watchdog timeout that arrives during a write aborts it. The target byte is left untouched, and a sticky error flag is set that survives the aborting reset, so firmware can detect the loss afterwards. A power-on reset puts the whole store into the erased state.

Top module: `nvm_ctl`

## Requirements
- R1: Selector code 0 reaches the location pointer, which keeps only its low log2(DEPTH) bits (6 by default) and reads the upper bits as 0. Code 1 reaches the data buffer, code 2 the control/status register, and code 3 the key port, which always reads 0x00.
- R2: A control write with bit 0 set, while no write is busy, copies the stored byte at the pointer into the data buffer on that clock edge. Bit 0 always reads back as 0.
- R3: A write starts only if the two bus writes just before the launching control write were 0x55 and then 0xAA to the key port. Any other order or value leaves busy at 0 and the store unchanged.
- R4: Any bus write that is not the expected next key value drops the unlock progress. This includes a write to another register placed between the second key and the launching control write.
- R5: The launching control write must itself carry bit 2 (enable) = 1 together with bit 1 (start). Bit 2 reads back as the last value written to it.
- R6: Once launched, bit 1 (busy) reads 1 for exactly WR_CYCLES cycles. On the edge that ends the write, the buffer byte is stored at the pointer, bit 1 returns to 0, and bit 4 (done) and `done_irq` go to 1.
- R7: Bit 4 holds at 1 until a control write carries 0 in bit 4. Writing 1 to it does nothing.
- R8: Software cannot clear bit 1 while a write is busy.
- R9: While a write is busy, writes to the pointer and the buffer are ignored, and so is a read request.
- R10: A warm reset (`rst_n` low) or a `wdt_to` pulse during a write aborts it. Bit 3 (error) becomes 1, the target byte keeps its old value, and the pointer, buffer, enable, done and busy bits clear. Bit 3 is cleared only by a control write with 0 in bit 3, or by power-on reset.
- R11: A warm reset with no write in progress leaves bit 3 at its previous value.
- R12: Power-on reset (`por_n` low) clears all registers, including bit 3, and sets every stored byte to ERASED (0xFF by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous warm reset, active low |
| wdt_to | input | 1 | Watchdog timeout pulse; acts as a warm reset |
| bus_sel | input | 2 | Register selector |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| done_irq | output | 1 | Level interrupt, equal to the done flag |

## Verification
The checker watches every cycle for the following: a write that ends clears busy and raises done, busy never drops early, an abort always leaves the error flag set, and a start is always preceded by an armed key sequence. It also checks that the pointer is frozen while busy and that done and error only clear through a control write carrying a 0 in their bit. The bench's scenarios are what show the ordering rules of the unlock sequence, the exact busy length, and the memory contents after completion, abort and power-on reset. Its cycle-accurate model also compares every readable register on each clock.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_BUF  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;

  localparam int CB_RD   = 0;
  localparam int CB_GO   = 1;
  localparam int CB_EN   = 2;
  localparam int CB_ERR  = 3;
  localparam int CB_DONE = 4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_ARMED} key_st_t;

  // next unlock state after one bus write
  function automatic key_st_t key_step(key_st_t cur, logic is_key, logic [7:0] d);
    if (is_key && d == KEY_FIRST) return KS_HALF;
    if (is_key && d == KEY_SECOND && cur == KS_HALF) return KS_ARMED;
    return KS_IDLE;
  endfunction

  function automatic logic [7:0] ctrl_image(logic done, logic err, logic en, logic busy);
    logic [7:0] v;
    v = 8'h00;
    v[CB_DONE] = done;
    v[CB_ERR]  = err;
    v[CB_EN]   = en;
    v[CB_GO]   = busy;
    return v;
  endfunction
endpackage

// File: rtl/nvm_key_seq.sv
`timescale 1ns/1ps
module nvm_key_seq
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm,
  input  logic       bus_we,
  input  logic       is_key,
  input  logic [7:0] wdata,
  output logic       armed
);
  key_st_t st;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      st <= KS_IDLE;
    else if (warm)   st <= KS_IDLE;
    else if (bus_we) st <= key_step(st, is_key, wdata);
  end

  assign armed = (st == KS_ARMED);
endmodule

// File: rtl/nvm_wr_timer.sv
`timescale 1ns/1ps
module nvm_wr_timer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm,
  input  logic start,
  output logic busy,
  output logic commit
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (warm) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(WR_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign commit = busy && (cnt == '0) && !warm;
endmodule

// File: rtl/nvm_store.sv
`timescale 1ns/1ps
module nvm_store #(
  parameter int         DEPTH  = 64,
  parameter logic [7:0] ERASED = 8'hFF,
  localparam int        AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/nvm_ctl.sv
`timescale 1ns/1ps
module nvm_ctl
  import nvm_pkg::*;
#(
  parameter int         DEPTH     = 64,
  parameter int         WR_CYCLES = 16,
  parameter logic [7:0] ERASED    = 8'hFF
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       wdt_to,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       done_irq
);
  localparam int AW = $clog2(DEPTH);

  logic          warm;
  logic          wr_ptr, wr_buf, wr_ctrl;
  logic          key_armed;
  logic          wr_start, wr_busy, wr_commit, wr_abort, rd_go;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, cell_q;
  logic          en_q, err_q, done_q;

  assign warm    = !rst_n || wdt_to;
  assign wr_ptr  = bus_we && (bus_sel == SEL_PTR);
  assign wr_buf  = bus_we && (bus_sel == SEL_BUF);
  assign wr_ctrl = bus_we && (bus_sel == SEL_CTRL);

  assign wr_start = wr_ctrl && bus_wdata[CB_GO] && bus_wdata[CB_EN] && key_armed && !wr_busy;
  assign rd_go    = wr_ctrl && bus_wdata[CB_RD] && !wr_busy;
  assign wr_abort = warm && wr_busy;

  nvm_key_seq u_key (
    .clk(clk), .por_n(por_n), .warm(warm), .bus_we(bus_we),
    .is_key(bus_sel == SEL_KEY), .wdata(bus_wdata), .armed(key_armed)
  );

  nvm_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .por_n(por_n), .warm(warm), .start(wr_start),
    .busy(wr_busy), .commit(wr_commit)
  );

  nvm_store #(.DEPTH(DEPTH), .ERASED(ERASED)) u_mem (
    .clk(clk), .por_n(por_n), .we(wr_commit), .addr(addr_q),
    .wdata(data_q), .rdata(cell_q)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q <= '0;
      data_q <= '0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (warm) begin
      addr_q <= '0;
      data_q <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= err_q || wr_busy;
    end else begin
      if (wr_ptr && !wr_busy) addr_q <= bus_wdata[AW-1:0];
      if (rd_go)                      data_q <= cell_q;
      else if (wr_buf && !wr_busy)    data_q <= bus_wdata;
      if (wr_ctrl) en_q <= bus_wdata[CB_EN];
      if (wr_ctrl && !bus_wdata[CB_ERR]) err_q <= 1'b0;
      if (wr_commit)                          done_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[CB_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_sel)
      SEL_PTR:  bus_rdata = 8'(addr_q);
      SEL_BUF:  bus_rdata = data_q;
      SEL_CTRL: bus_rdata = ctrl_image(done_q, err_q, en_q, wr_busy);
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign done_irq = done_q;
endmodule

// File: rtl/nvm_ctl_chk.sv
`timescale 1ns/1ps
module nvm_ctl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          por_n,
  input logic          warm,
  input logic          busy,
  input logic          commit,
  input logic          abort,
  input logic          armed,
  input logic          err,
  input logic          done,
  input logic [AW-1:0] addr_q,
  input logic          bus_we,
  input logic [1:0]    bus_sel,
  input logic [7:0]    bus_wdata
);
  logic ctrl_wr;
  assign ctrl_wr = bus_we && (bus_sel == 2'd2);

  a_r6_commit_ends_write: assert property (@(posedge clk) disable iff (!por_n)
    commit |=> (!busy && done));

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !commit && !warm) |=> busy);

  a_r10_abort_flags_error: assert property (@(posedge clk) disable iff (!por_n)
    abort |=> err);

  a_r3_start_needs_unlock: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(armed));

  a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !warm) |=> $stable(addr_q));

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (err && !(ctrl_wr && !bus_wdata[3])) |=> err);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (done && !warm && !(ctrl_wr && !bus_wdata[4])) |=> done);
endmodule

bind nvm_ctl nvm_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .warm(warm), .busy(wr_busy), .commit(wr_commit),
  .abort(wr_abort), .armed(key_armed), .err(err_q), .done(done_q),
  .addr_q(addr_q), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata)
);

// File: tb/tb_nvm_ctl.sv
`timescale 1ns/1ps
module tb_nvm_ctl;
  localparam int W = 16;
  localparam int D = 64;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_n = 1'b1;
  logic       wdt_to = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       done_irq;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nvm_ctl #(.DEPTH(D), .WR_CYCLES(W), .ERASED(8'hFF)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wdt_to(wdt_to),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done_irq(done_irq)
  );

  // behavioural reference model
  int m_mem [D];
  int m_addr, m_data, m_key, m_left;
  bit m_en, m_err, m_done;

  function automatic int m_view(int sel);
    case (sel)
      0: return m_addr;
      1: return m_data;
      2: return (m_done ? 16 : 0) + (m_err ? 8 : 0) + (m_en ? 4 : 0) + (m_left > 0 ? 2 : 0);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      foreach (m_mem[i]) m_mem[i] = 255;
      m_addr = 0; m_data = 0; m_key = 0; m_left = 0;
      m_en = 0; m_err = 0; m_done = 0;
    end else begin
      bit was_busy, fin;
      was_busy = (m_left > 0);
      fin = 0;
      if (!rst_n || wdt_to) begin
        if (was_busy) m_err = 1;
        m_addr = 0; m_data = 0; m_en = 0; m_done = 0; m_left = 0; m_key = 0;
      end else begin
        if (was_busy) begin
          m_left--;
          if (m_left == 0) fin = 1;
        end
        if (bus_we) begin
          int nk;
          nk = 0;
          if (bus_sel == 3 && bus_wdata == 8'h55) nk = 1;
          else if (bus_sel == 3 && bus_wdata == 8'hAA && m_key == 1) nk = 2;
          case (bus_sel)
            0: if (!was_busy) m_addr = bus_wdata % D;
            1: if (!was_busy) m_data = bus_wdata;
            2: begin
              m_en = bus_wdata[2];
              if (!bus_wdata[3]) m_err = 0;
              if (!bus_wdata[4]) m_done = 0;
              if (bus_wdata[0] && !was_busy) m_data = m_mem[m_addr];
              if (bus_wdata[1] && bus_wdata[2] && m_key == 2 && !was_busy) m_left = W;
            end
            default: ;
          endcase
          m_key = nk;
        end
        if (fin) begin
          m_mem[m_addr] = m_data;
          m_done = 1;
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (por_n) begin
      checks++;
      if (bus_rdata != 8'(m_view(int'(bus_sel))) || done_irq != m_done) begin
        fails++;
        $display("FAIL R1 model sel=%0d: rdata=%h irq=%0b expected rdata=%h irq=%0b",
                 bus_sel, bus_rdata, done_irq, 8'(m_view(int'(bus_sel))), m_done);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(posedge clk); #2;
    bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(posedge clk); #2;
    bus_sel = s; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic unlock();
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
  endtask

  task automatic pulse_warm(input bit use_wdt);
    @(posedge clk); #2;
    if (use_wdt) wdt_to = 1'b1; else rst_n = 1'b0;
    @(posedge clk); #2;
    wdt_to = 1'b0; rst_n = 1'b1;
  endtask

  task automatic peek_cell(input logic [7:0] a, input logic [7:0] ctl, output logic [7:0] v);
    wr(2'd0, a);
    wr(2'd2, ctl);
    rd(2'd1, v);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    idle(2);
    @(posedge clk); #2 por_n = 1'b1;

    // R12 reset state
    rd(2'd0, v); chk("R12 ptr after por", v, 8'h00);
    rd(2'd1, v); chk("R12 buf after por", v, 8'h00);
    rd(2'd2, v); chk("R12 ctrl after por", v, 8'h00);
    chk("R12 irq after por", {7'd0, done_irq}, 8'h00);
    peek_cell(8'd5, 8'h01, v); chk("R12 erased cell / R2 read", v, 8'hFF);
    rd(2'd2, v); chk("R2 read bit reads 0", v, 8'h00);

    // R1 register map
    wr(2'd0, 8'h7F); rd(2'd0, v); chk("R1 ptr masks to 6 bits", v, 8'h3F);
    wr(2'd1, 8'h96); rd(2'd1, v); chk("R1 buf readback", v, 8'h96);
    wr(2'd3, 8'h55); rd(2'd3, v); chk("R1 key reads zero", v, 8'h00);

    // R6 full write
    wr(2'd0, 8'd5); wr(2'd1, 8'hA5);
    unlock();
    wr(2'd2, 8'h06);
    n = 0;
    #1;
    while (bus_rdata[1]) begin
      n++;
      @(posedge clk); #3;
    end
    chk("R6 busy length", 8'(n), 8'(W));
    rd(2'd2, v); chk("R6 done after write", v, 8'h14);
    chk("R6 irq raised", {7'd0, done_irq}, 8'h01);
    wr(2'd2, 8'h14); rd(2'd2, v); chk("R7 writing 1 keeps done", v, 8'h14);
    wr(2'd2, 8'h00); rd(2'd2, v); chk("R7 writing 0 clears done", v, 8'h00);
    chk("R7 irq cleared", {7'd0, done_irq}, 8'h00);
    wr(2'd1, 8'h00);
    peek_cell(8'd5, 8'h01, v); chk("R6 stored byte", v, 8'hA5);

    // R3 refused starts
    wr(2'd0, 8'd6); wr(2'd1, 8'h11);
    wr(2'd2, 8'h06); rd(2'd2, v); chk("R3 no key refused", v, 8'h04);
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55);
    wr(2'd2, 8'h06); rd(2'd2, v); chk("R3 reversed keys refused", v, 8'h04);
    // R4 interrupted sequences
    unlock(); wr(2'd1, 8'h11);
    wr(2'd2, 8'h06); rd(2'd2, v); chk("R4 reg write after keys cancels", v, 8'h04);
    wr(2'd3, 8'h55); wr(2'd3, 8'h12); wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06); rd(2'd2, v); chk("R4 wrong middle key cancels", v, 8'h04);
    // R5 enable required
    unlock();
    wr(2'd2, 8'h02); rd(2'd2, v); chk("R5 no enable refused", v, 8'h00);
    idle(W + 2);
    peek_cell(8'd6, 8'h01, v); chk("R3 cell unchanged", v, 8'hFF);

    // R8 / R9 during busy
    wr(2'd0, 8'd7); wr(2'd1, 8'h5A);
    unlock();
    wr(2'd2, 8'h06);
    wr(2'd2, 8'h04); rd(2'd2, v); chk("R8 busy not clearable", v, 8'h06);
    wr(2'd0, 8'h20); rd(2'd0, v); chk("R9 ptr write ignored", v, 8'h07);
    wr(2'd1, 8'h00); rd(2'd1, v); chk("R9 buf write ignored", v, 8'h5A);
    wr(2'd2, 8'h05); rd(2'd1, v); chk("R9 read request ignored", v, 8'h5A);
    idle(W);
    rd(2'd2, v); chk("R6 second write done", v, 8'h14);
    wr(2'd1, 8'h00);
    peek_cell(8'd7, 8'h01, v); chk("R9 stored byte intact", v, 8'h5A);

    // R10 abort by warm reset
    wr(2'd0, 8'd9); wr(2'd1, 8'h3C);
    unlock();
    wr(2'd2, 8'h06);
    idle(3);
    pulse_warm(1'b0);
    rd(2'd2, v); chk("R10 warm abort sets error", v, 8'h08);
    rd(2'd0, v); chk("R10 ptr cleared", v, 8'h00);
    peek_cell(8'd9, 8'h09, v); chk("R10 target unchanged (reset)", v, 8'hFF);
    wr(2'd2, 8'h00); rd(2'd2, v); chk("R10 error cleared by 0", v, 8'h00);

    // R10 abort by watchdog
    wr(2'd0, 8'd10); wr(2'd1, 8'hC3);
    unlock();
    wr(2'd2, 8'h06);
    idle(W - 4);
    pulse_warm(1'b1);
    rd(2'd2, v); chk("R10 watchdog abort sets error", v, 8'h08);
    peek_cell(8'd10, 8'h09, v); chk("R10 target unchanged (watchdog)", v, 8'hFF);

    // R11 idle warm reset keeps error
    pulse_warm(1'b0);
    rd(2'd2, v); chk("R11 error survives idle reset", v, 8'h08);

    // R12 power-on reset
    @(posedge clk); #2 por_n = 1'b0;
    @(posedge clk); #2 por_n = 1'b1;
    rd(2'd2, v); chk("R12 por clears error", v, 8'h00);
    peek_cell(8'd5, 8'h01, v); chk("R12 por erases store", v, 8'hFF);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule